// File: doc/BRIEF.md
# Two-Level Half-Duplex Bus Hub Router

This block is the routing core of a half-duplex bus hub. The hub has one upstream port facing the bus master and a parameterised number of downstream segment ports (ten by default). Every port is a half-duplex line with three signals: a receive input, a transmit data output and a driver enable output. Whatever the master sends on the upstream port is repeated onto every downstream segment at once. Whatever any node sends on a downstream segment goes back to the master only. Nodes on the other segments never see it. Nodes on the same segment see it because they share the wire. Nothing is buffered: each bit passes through with one clock of latency.

Which way data flows is decided by whichever side pulls its line low first while the hub is quiet. A direction flag then holds until every line has stayed high for `IDLE_CYC` consecutive cycles. While that flag is held, the lines that the hub itself is driving are ignored, so the hub never forwards its own echo back. Each transmitting port uses a fast-release direction scheme. A 0 is driven actively. A 0-to-1 transition is driven high actively for `HOLD_CYC` cycles so that the rising edge is sharp. After that the driver releases, and the line's bias holds it at 1.

Top module: `hub_router`

## Requirements
- R1: During reset and after reset with all lines high, every port is released: driver enable 0 and transmit data 1.
- R2: When the hub is quiet and the upstream receive line is sampled low, every downstream port drives 0 (enable 1, data 0) on the next cycle, and the upstream port stays released.
- R3: While traffic flows downstream, every downstream port carries the upstream receive value from one cycle earlier, and all downstream ports carry identical values.
- R4: When the hub is quiet and any downstream receive line is sampled low, the logical AND of all downstream receive lines is forwarded to the upstream port with one cycle of latency.
- R5: Traffic arriving on a downstream port never drives any downstream port: the upstream enable and any downstream enable are never 1 together.
- R6: A forwarded 0 is driven with enable 1 and data 0. A forwarded 1 that directly follows a driven 0 is driven with enable 1 and data 1 for exactly `HOLD_CYC` cycles. After that the port releases (enable 0, data 1) while the forwarded value stays 1.
- R7: While traffic flows downstream, downstream receive lines have no effect on the upstream port. While traffic flows upstream, the upstream receive line has no effect on any downstream port.
- R8: The flow direction returns to quiet only after all receive lines have been high for `IDLE_CYC` consecutive cycles, at which point every port releases. A low on any line restarts that count.
- R9: If the upstream line and a downstream line are first sampled low in the same quiet cycle, the direction becomes downstream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| host_rx | input | 1 | Upstream port receive data (idle 1) |
| host_tx | output | 1 | Upstream port transmit data |
| host_de | output | 1 | Upstream port driver enable |
| slv_rx | input | N_SLV | Downstream ports receive data (idle 1) |
| slv_tx | output | N_SLV | Downstream ports transmit data |
| slv_de | output | N_SLV | Downstream ports driver enables |

## Verification
The checker assumes that `IDLE_CYC` is larger than `HOLD_CYC` and is at least 2. Under that assumption the direction cannot fall back to quiet on the cycle right after a driven 0, and every new drive therefore starts with a 0. The checker also assumes that the receive inputs change only between clock edges. The stimulus keeps to the default parameter values and changes inputs only on falling edges. It includes illegal echoes, simultaneous starts and near-expiry quiet windows, because the bench model specifies the response to each of these inputs exactly.

// File: rtl/hub_pkg.sv
package hub_pkg;

  typedef enum logic [1:0] {
    FLOW_QUIET = 2'd0,
    FLOW_DOWN  = 2'd1,
    FLOW_UP    = 2'd2
  } flow_e;

endpackage

// File: rtl/hub_flow_ctrl.sv
module hub_flow_ctrl
  import hub_pkg::*;
#(
  parameter int N_SLV    = 10,
  parameter int IDLE_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_rx,
  input  logic [N_SLV-1:0] slv_rx,
  output logic             dn_en,
  output logic             up_en,
  output logic             fwd_dat
);

  localparam int QW = (IDLE_CYC < 2) ? 1 : $clog2(IDLE_CYC + 1);
  localparam logic [QW-1:0] Q_LAST = QW'(IDLE_CYC - 1);

  flow_e         flow_q, flow_nxt;
  logic [QW-1:0] quiet_q, quiet_nxt;
  logic          up_and, all_hi;

  // Wired-AND of the downstream segments: idle lines read 1
  assign up_and = &slv_rx;
  assign all_hi = host_rx & up_and;

  always_comb begin
    flow_nxt = flow_q;
    case (flow_q)
      FLOW_QUIET: begin
        if (!host_rx)     flow_nxt = FLOW_DOWN;
        else if (!up_and) flow_nxt = FLOW_UP;
      end
      default: begin
        if (all_hi && (quiet_q == Q_LAST)) flow_nxt = FLOW_QUIET;
      end
    endcase
  end

  always_comb begin
    if ((flow_q == FLOW_QUIET) || !all_hi) quiet_nxt = '0;
    else                                   quiet_nxt = quiet_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flow_q  <= FLOW_QUIET;
      quiet_q <= '0;
    end else begin
      flow_q  <= flow_nxt;
      quiet_q <= quiet_nxt;
    end
  end

  // Source selection follows the direction decided this cycle, so the
  // first low bit is forwarded with the same latency as the rest.
  always_comb begin
    dn_en   = (flow_nxt == FLOW_DOWN);
    up_en   = (flow_nxt == FLOW_UP);
    fwd_dat = 1'b1;
    if (dn_en)      fwd_dat = host_rx;
    else if (up_en) fwd_dat = up_and;
  end

endmodule

// File: rtl/hub_line_drv.sv
module hub_line_drv #(
  parameter int HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic dat,
  output logic tx,
  output logic de
);

  localparam int HW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] H_LOAD = HW'(HOLD_CYC - 1);

  logic          tx_q, de_q, tx_nxt, de_nxt;
  logic [HW-1:0] hold_q, hold_nxt;
  logic          hold_ce;

  always_comb begin
    tx_nxt   = 1'b1;
    de_nxt   = 1'b0;
    hold_nxt = '0;
    if (en) begin
      if (!dat) begin
        tx_nxt = 1'b0;
        de_nxt = 1'b1;
      end else if (de_q && !tx_q) begin
        de_nxt   = 1'b1;
        hold_nxt = H_LOAD;
      end else if (hold_q != '0) begin
        de_nxt   = 1'b1;
        hold_nxt = hold_q - 1'b1;
      end
    end
  end

  // Counter only toggles while it is loaded or being loaded
  assign hold_ce = (hold_q != '0) || (hold_nxt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= 1'b1;
      de_q <= 1'b0;
    end else begin
      tx_q <= tx_nxt;
      de_q <= de_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_ce) hold_q <= hold_nxt;
  end

  assign tx = tx_q;
  assign de = de_q;

endmodule

// File: rtl/hub_router.sv
module hub_router #(
  parameter int N_SLV    = 10,
  parameter int HOLD_CYC = 4,
  parameter int IDLE_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_rx,
  output logic             host_tx,
  output logic             host_de,
  input  logic [N_SLV-1:0] slv_rx,
  output logic [N_SLV-1:0] slv_tx,
  output logic [N_SLV-1:0] slv_de
);

  logic dn_en, up_en, fwd_dat;

  hub_flow_ctrl #(
    .N_SLV   (N_SLV),
    .IDLE_CYC(IDLE_CYC)
  ) u_flow (
    .clk    (clk),
    .rst_n  (rst_n),
    .host_rx(host_rx),
    .slv_rx (slv_rx),
    .dn_en  (dn_en),
    .up_en  (up_en),
    .fwd_dat(fwd_dat)
  );

  hub_line_drv #(.HOLD_CYC(HOLD_CYC)) u_host_drv (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (up_en),
    .dat  (fwd_dat),
    .tx   (host_tx),
    .de   (host_de)
  );

  for (genvar g = 0; g < N_SLV; g++) begin : g_slv
    hub_line_drv #(.HOLD_CYC(HOLD_CYC)) u_drv (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (dn_en),
      .dat  (fwd_dat),
      .tx   (slv_tx[g]),
      .de   (slv_de[g])
    );
  end

endmodule

// File: rtl/hub_router_chk.sv
module hub_router_chk #(
  parameter int N_SLV = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_tx,
  input logic             host_de,
  input logic [N_SLV-1:0] slv_tx,
  input logic [N_SLV-1:0] slv_de
);

  // R5
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_de && (|slv_de)));

  // R3
  dn_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_de == '0) || ((slv_de == '1) && (slv_tx == {N_SLV{slv_tx[0]}})));

  // R6
  host_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_de) |-> !host_tx);

  // R6
  slv_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slv_de[0]) |-> !slv_tx[0]);

  // R6
  host_low_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_de && !host_tx) |=> host_de);

  // R1
  released_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_de |-> host_tx);

endmodule

bind hub_router hub_router_chk #(.N_SLV(N_SLV)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .host_tx(host_tx),
  .host_de(host_de),
  .slv_tx (slv_tx),
  .slv_de (slv_de)
);

// File: tb/hub_router_tb.sv
`timescale 1ns/1ps
module hub_router_tb;

  localparam int N_SLV    = 10;
  localparam int HOLD_CYC = 4;
  localparam int IDLE_CYC = 16;

  logic             clk;
  logic             rst_n;
  logic             host_rx;
  logic             host_tx, host_de;
  logic [N_SLV-1:0] slv_rx;
  logic [N_SLV-1:0] slv_tx, slv_de;

  int    vectors;
  int    miscompares;
  string req;

  // Reference model state: index 0 = upstream, 1..N_SLV = downstream
  int   m_flow;   // 0 quiet, 1 down, 2 up
  int   m_quiet;
  int   m_hold [0:N_SLV];
  logic e_tx   [0:N_SLV];
  logic e_de   [0:N_SLV];

  hub_router #(
    .N_SLV   (N_SLV),
    .HOLD_CYC(HOLD_CYC),
    .IDLE_CYC(IDLE_CYC)
  ) u_dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .host_rx(host_rx),
    .host_tx(host_tx),
    .host_de(host_de),
    .slv_rx (slv_rx),
    .slv_tx (slv_tx),
    .slv_de (slv_de)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic model_reset();
    m_flow  = 0;
    m_quiet = 0;
    for (int p = 0; p <= N_SLV; p++) begin
      m_hold[p] = 0;
      e_tx[p]   = 1'b1;
      e_de[p]   = 1'b0;
    end
  endtask

  // Predicts the outputs after the next rising edge from current inputs
  task automatic model_step();
    logic seg_and, all_hi, src, en;
    int   nf;
    seg_and = &slv_rx;
    all_hi  = host_rx & seg_and;
    nf      = m_flow;
    if (m_flow == 0) begin
      if (!host_rx)      nf = 1;
      else if (!seg_and) nf = 2;
    end else if (all_hi && m_quiet == IDLE_CYC - 1) begin
      nf = 0;
    end
    m_quiet = (m_flow == 0 || !all_hi) ? 0 : m_quiet + 1;
    m_flow  = nf;
    src = (nf == 1) ? host_rx : (nf == 2) ? seg_and : 1'b1;
    for (int p = 0; p <= N_SLV; p++) begin
      en = (p == 0) ? (nf == 2) : (nf == 1);
      if (!en) begin
        e_tx[p] = 1'b1; e_de[p] = 1'b0; m_hold[p] = 0;
      end else if (!src) begin
        e_tx[p] = 1'b0; e_de[p] = 1'b1; m_hold[p] = 0;
      end else if (e_de[p] && !e_tx[p]) begin
        e_tx[p] = 1'b1; e_de[p] = 1'b1; m_hold[p] = HOLD_CYC - 1;
      end else if (m_hold[p] > 0) begin
        e_tx[p] = 1'b1; e_de[p] = 1'b1; m_hold[p] = m_hold[p] - 1;
      end else begin
        e_tx[p] = 1'b1; e_de[p] = 1'b0; m_hold[p] = 0;
      end
    end
  endtask

  task automatic compare();
    logic a_tx, a_de;
    vectors++;
    for (int p = 0; p <= N_SLV; p++) begin
      a_tx = (p == 0) ? host_tx : slv_tx[p-1];
      a_de = (p == 0) ? host_de : slv_de[p-1];
      if (a_tx !== e_tx[p] || a_de !== e_de[p]) begin
        miscompares++;
        $display("FAIL %s port %0d: actual tx=%b de=%b expected tx=%b de=%b (t=%0t)",
                 req, p, a_tx, a_de, e_tx[p], e_de[p], $time);
      end
    end
  endtask

  // One cycle: check outputs, apply next inputs, advance model
  task automatic step(input logic h, input logic [N_SLV-1:0] s);
    @(negedge clk);
    compare();
    host_rx = h;
    slv_rx  = s;
    model_step();
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) step(1'b1, '1);
  endtask

  task automatic host_byte(input logic [7:0] b);
    step(1'b0, '1);
    for (int i = 0; i < 8; i++) step(b[i], '1);
    step(1'b1, '1);
  endtask

  task automatic seg_byte(input logic [N_SLV-1:0] who, input logic [7:0] b);
    step(1'b1, ~who);
    for (int i = 0; i < 8; i++) step(1'b1, b[i] ? '1 : ~who);
    step(1'b1, '1);
  endtask

  initial begin
    vectors = 0; miscompares = 0; req = "R1";
    rst_n = 1'b0; host_rx = 1'b1; slv_rx = '1;
    model_reset();
    repeat (3) begin
      @(negedge clk);
      compare();
    end
    rst_n = 1'b1;
    model_step();
    quiet(4);                                   // R1

    req = "R2";  host_byte(8'h00);
    req = "R8";  quiet(IDLE_CYC + 2);
    req = "R3";  host_byte(8'hA5);
    quiet(IDLE_CYC + 2);
    host_byte(8'h55);
    quiet(IDLE_CYC + 2);
    req = "R6";  host_byte(8'hF0);             // long high run releases after hold
    step(1'b0, '1); step(1'b1, '1); step(1'b0, '1);
    repeat (HOLD_CYC + 3) step(1'b1, '1);
    quiet(IDLE_CYC + 2);

    req = "R7";                                 // echo of segment lines during downstream
    step(1'b0, '1);
    step(1'b1, 10'b1111110111);
    step(1'b0, 10'b0000000000);
    step(1'b1, 10'b0101010101);
    step(1'b1, '1);
    quiet(IDLE_CYC + 2);

    req = "R4 R5"; seg_byte(10'b0000100000, 8'h3C);
    quiet(IDLE_CYC + 2);
    seg_byte(10'b1000000001, 8'hC3);           // two segments, wired-AND
    step(1'b1, 10'b1111111110); step(1'b1, 10'b0111111111);
    step(1'b1, '1);
    quiet(IDLE_CYC + 2);

    req = "R7";                                 // upstream echo ignored
    step(1'b1, 10'b1111101111);
    step(1'b0, '1); step(1'b0, '1); step(1'b1, '1);
    quiet(IDLE_CYC + 2);

    req = "R8";                                 // count restart, near-expiry low
    step(1'b1, 10'b1110111111);
    quiet(IDLE_CYC - 1);
    step(1'b0, '1);                             // still upstream: ignored
    quiet(IDLE_CYC - 1);
    step(1'b1, 10'b1110111111);
    quiet(IDLE_CYC + 1);
    step(1'b0, '1);                             // now quiet: starts downstream
    step(1'b1, '1);
    quiet(IDLE_CYC + 2);

    req = "R9";
    step(1'b0, 10'b1111111011);
    step(1'b1, 10'b1111111011);
    step(1'b0, '1);
    quiet(IDLE_CYC + 2);

    req = "R3 R4 R7";                           // mixed random traffic
    for (int k = 0; k < 600; k++) begin
      logic [N_SLV-1:0] s;
      logic             h;
      h = ($urandom_range(0, 3) != 0);
      s = '1;
      if ($urandom_range(0, 3) == 0) s[$urandom_range(0, N_SLV-1)] = 1'b0;
      step(h, s);
      if (k % 100 == 99) quiet(IDLE_CYC + 2);
    end
    quiet(IDLE_CYC + 2);

    @(negedge clk);
    compare();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 20);
    miscompares++;
    $display("FAIL watchdog: actual run still active, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule